// File: doc/BRIEF.md
# Nonlinear ECC Decode Outcome Controller

This block is the final decision stage of a decoder that pairs a linear multi-bit code with a nonlinear check field. Upstream engines do the arithmetic. One computes the linear syndrome and the nonlinear syndrome. Another finds error locations and reports how many there are. A third recomputes the nonlinear syndrome over corrected data. This controller sequences those engines. It also decides whether the word is clean, can be repaired, or cannot be recovered.

A decode begins with a start pulse. When the linear syndrome is zero, locating is skipped and the result is ready on the following cycle. Otherwise the controller requests a location pass and classifies the reported error count. Errors that fall only in the check part are reported as no error and are not corrected. When data bits are in error, the controller requests a recomputed nonlinear syndrome and spends one verification cycle on it. It commits the correction only if that recomputed syndrome is zero.

The verdict and the done flag are registered. They stay unchanged until the next accepted start.

Top module: `nlecc_decide`

## Requirements
- R1: While rst_n is low, and after it is released, the block is idle with done, err, commit, search_req and recheck_req all 0.
- R2: When syn_vld is sampled with lin_syn_zero=1, done rises on the next cycle with err=1 if nl_syn is nonzero and err=0 otherwise. search_req and commit stay 0.
- R3: When syn_vld is sampled with lin_syn_zero=0, search_req is a single-cycle pulse on the next cycle and done stays 0.
- R4: err_cnt is 4-bit two's complement, where 4'b1111 is -1 (decoder failure). When loc_vld is sampled with a negative count, or a count above T_MAX=5, done rises on the next cycle with err=1 and no commit.
- R5: When loc_vld is sampled with err_cnt=0, done rises on the next cycle. err is 1 exactly when the nl_syn captured with syn_vld was nonzero.
- R6: When loc_vld is sampled with a count of 1 to 5 and info_hit=0, done rises on the next cycle with err=0. No commit or recheck_req occurs.
- R7: When loc_vld is sampled with a count of 1 to 5 and info_hit=1, recheck_req pulses on the next cycle. After re_vld is sampled there is exactly one verify cycle, and then done rises. If re_syn is zero, done comes with err=0 and commit=1. Otherwise it comes with err=1 and no commit.
- R8: done and err hold their values until a start is sampled in idle. The cycle after that start, both are 0.
- R9: A start pulse while a decode is in progress is ignored, and the decode in flight completes normally.
- R10: commit is a one-cycle pulse that appears only in the cycle done rises, and only with err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| start | input | 1 | begin a decode (accepted only in idle) |
| syn_vld | input | 1 | syndromes are valid |
| lin_syn_zero | input | 1 | linear syndrome is all zero |
| nl_syn | input | SYN_W | nonlinear syndrome of the received word |
| loc_vld | input | 1 | locating result is valid |
| err_cnt | input | CNT_W | located error count, two's complement, -1 is failure |
| info_hit | input | 1 | a located error lies in the data bits |
| re_vld | input | 1 | recomputed nonlinear syndrome is valid |
| re_syn | input | SYN_W | nonlinear syndrome over the corrected data |
| search_req | output | 1 | pulse requesting the error-locating pass |
| recheck_req | output | 1 | pulse requesting a recomputed nonlinear syndrome |
| commit | output | 1 | pulse committing the correction |
| done | output | 1 | decode finished, held until next start |
| err | output | 1 | uncorrectable error verdict, held with done |

## Verification
The bench targets the boundaries of the count field and the ways a decode can finish. It drives -1, -2, 0, 5, 6 and 7 as counts. A design that treats the count as unsigned or compares against the wrong limit would commit or pass a word that should fail. It checks the exact cycle done rises on the early-exit path and on the verify path. A design that skips the verify cycle or still waits for locating would finish one cycle off. It also covers a recomputed syndrome that comes back nonzero, check-only errors, a start arriving mid-decode, and a reset mid-decode. These catch a commit that does not wait for verification, a spurious recheck, and a restart that drops the decode in flight.

// File: rtl/nlecc_pkg.sv
package nlecc_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WSYN = 3'd1,
    S_WLOC = 3'd2,
    S_WRE  = 3'd3,
    S_VER  = 3'd4
  } nl_state_e;

  typedef enum logic [1:0] {
    O_PASS = 2'd0,
    O_FAIL = 2'd1,
    O_SKIP = 2'd2,
    O_FIX  = 2'd3
  } nl_outcome_e;
endpackage

// File: rtl/nlecc_zdet.sv
module nlecc_zdet #(
  parameter int W = 10
) (
  input  logic [W-1:0] vec,
  output logic         nz
);
  assign nz = |vec;
endmodule

// File: rtl/nlecc_classify.sv
module nlecc_classify
  import nlecc_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_MAX = 5
) (
  input  logic [CNT_W-1:0] err_cnt,
  input  logic             info_hit,
  input  logic             nl_nz_held,
  output nl_outcome_e      outcome
);
  localparam logic signed [CNT_W-1:0] LIMIT = CNT_W'(T_MAX);

  logic signed [CNT_W-1:0] cnt_s;
  assign cnt_s = $signed(err_cnt);

  always_comb begin
    if (cnt_s < 0 || cnt_s > LIMIT) begin
      outcome = O_FAIL;
    end else if (cnt_s == 0) begin
      outcome = nl_nz_held ? O_FAIL : O_PASS;
    end else if (!info_hit) begin
      outcome = O_SKIP;
    end else begin
      outcome = O_FIX;
    end
  end
endmodule

// File: rtl/nlecc_fsm.sv
module nlecc_fsm
  import nlecc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        syn_vld,
  input  logic        lin_syn_zero,
  input  logic        nl_nz,
  input  logic        loc_vld,
  input  nl_outcome_e outcome,
  input  logic        re_vld,
  input  logic        re_nz,
  output logic        nl_nz_held,
  output logic        search_req,
  output logic        recheck_req,
  output logic        commit,
  output logic        done,
  output logic        err,
  output nl_state_e   st
);
  nl_state_e st_q, st_n;
  logic done_q, done_n, err_q, err_n;
  logic cmt_q, cmt_n, srch_q, srch_n, rchk_q, rchk_n;
  logic nlh_q, nlh_en, renz_q, renz_en;

  always_comb begin
    st_n    = st_q;
    done_n  = done_q;
    err_n   = err_q;
    cmt_n   = 1'b0;
    srch_n  = 1'b0;
    rchk_n  = 1'b0;
    nlh_en  = 1'b0;
    renz_en = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_n   = S_WSYN;
          done_n = 1'b0;
          err_n  = 1'b0;
        end
      end
      S_WSYN: begin
        if (syn_vld) begin
          nlh_en = 1'b1;
          if (lin_syn_zero) begin
            st_n   = S_IDLE;
            done_n = 1'b1;
            err_n  = nl_nz;
          end else begin
            st_n   = S_WLOC;
            srch_n = 1'b1;
          end
        end
      end
      S_WLOC: begin
        if (loc_vld) begin
          case (outcome)
            O_FIX: begin
              st_n   = S_WRE;
              rchk_n = 1'b1;
            end
            O_FAIL: begin
              st_n   = S_IDLE;
              done_n = 1'b1;
              err_n  = 1'b1;
            end
            default: begin
              st_n   = S_IDLE;
              done_n = 1'b1;
              err_n  = 1'b0;
            end
          endcase
        end
      end
      S_WRE: begin
        if (re_vld) begin
          renz_en = 1'b1;
          st_n    = S_VER;
        end
      end
      S_VER: begin
        st_n   = S_IDLE;
        done_n = 1'b1;
        err_n  = renz_q;
        cmt_n  = !renz_q;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cmt_q  <= 1'b0;
      srch_q <= 1'b0;
      rchk_q <= 1'b0;
      nlh_q  <= 1'b0;
      renz_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      cmt_q  <= cmt_n;
      srch_q <= srch_n;
      rchk_q <= rchk_n;
      if (nlh_en)  nlh_q  <= nl_nz;
      if (renz_en) renz_q <= re_nz;
    end
  end

  assign nl_nz_held  = nlh_q;
  assign search_req  = srch_q;
  assign recheck_req = rchk_q;
  assign commit      = cmt_q;
  assign done        = done_q;
  assign err         = err_q;
  assign st          = st_q;
endmodule

// File: rtl/nlecc_decide.sv
module nlecc_decide
  import nlecc_pkg::*;
#(
  parameter int SYN_W = 10,
  parameter int CNT_W = 4,
  parameter int T_MAX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             syn_vld,
  input  logic             lin_syn_zero,
  input  logic [SYN_W-1:0] nl_syn,
  input  logic             loc_vld,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic             info_hit,
  input  logic             re_vld,
  input  logic [SYN_W-1:0] re_syn,
  output logic             search_req,
  output logic             recheck_req,
  output logic             commit,
  output logic             done,
  output logic             err
);
  logic        nl_nz, re_nz, nl_nz_held;
  nl_outcome_e outcome;
  nl_state_e   st;

  nlecc_zdet #(.W(SYN_W)) u_nlz (.vec(nl_syn), .nz(nl_nz));
  nlecc_zdet #(.W(SYN_W)) u_rez (.vec(re_syn), .nz(re_nz));

  nlecc_classify #(.CNT_W(CNT_W), .T_MAX(T_MAX)) u_cls (
    .err_cnt(err_cnt), .info_hit(info_hit), .nl_nz_held(nl_nz_held),
    .outcome(outcome)
  );

  nlecc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .syn_vld(syn_vld),
    .lin_syn_zero(lin_syn_zero), .nl_nz(nl_nz), .loc_vld(loc_vld),
    .outcome(outcome), .re_vld(re_vld), .re_nz(re_nz),
    .nl_nz_held(nl_nz_held), .search_req(search_req),
    .recheck_req(recheck_req), .commit(commit), .done(done), .err(err),
    .st(st)
  );
endmodule

// File: rtl/nlecc_decide_chk.sv
module nlecc_decide_chk
  import nlecc_pkg::*;
#(
  parameter int SYN_W = 10,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             syn_vld,
  input logic             lin_syn_zero,
  input logic             loc_vld,
  input logic [CNT_W-1:0] err_cnt,
  input logic             re_vld,
  input logic [SYN_W-1:0] re_syn,
  input logic             search_req,
  input logic             commit,
  input logic             done,
  input logic             err,
  input nl_state_e        st
);
  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !done && !err && !commit && !search_req);

  p_early_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WSYN && syn_vld && lin_syn_zero) |=> done && !search_req);

  p_search_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    search_req |-> $past(syn_vld) && !$past(lin_syn_zero));

  p_fail_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WLOC && loc_vld && err_cnt[CNT_W-1]) |=> done && err && !commit);

  p_commit_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(re_vld, 2) && ($past(re_syn, 2) == '0));

  p_hold_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(err));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WLOC && start && !loc_vld) |=> st == S_WLOC);

  p_commit_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> done && !err && $rose(done));

  p_commit_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

bind nlecc_decide nlecc_decide_chk #(.SYN_W(SYN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .syn_vld(syn_vld),
  .lin_syn_zero(lin_syn_zero), .loc_vld(loc_vld), .err_cnt(err_cnt),
  .re_vld(re_vld), .re_syn(re_syn), .search_req(search_req),
  .commit(commit), .done(done), .err(err), .st(st)
);

// File: tb/sim_nlecc_decide.sv
module sim_nlecc_decide;
  logic       clk, rst_n, start, syn_vld, lin_syn_zero, loc_vld, info_hit, re_vld;
  logic [9:0] nl_syn, re_syn;
  logic [3:0] err_cnt;
  logic       search_req, recheck_req, commit, done, err;

  int total = 0;
  int bad   = 0;
  logic [1:0] exp_q[$];
  logic       done_d;

  nlecc_decide u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .syn_vld(syn_vld),
    .lin_syn_zero(lin_syn_zero), .nl_syn(nl_syn), .loc_vld(loc_vld),
    .err_cnt(err_cnt), .info_hit(info_hit), .re_vld(re_vld), .re_syn(re_syn),
    .search_req(search_req), .recheck_req(recheck_req), .commit(commit),
    .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: scoreboard of {err, commit} popped when done rises
  always @(negedge clk) begin
    if (!rst_n) begin
      done_d <= 1'b0;
    end else begin
      done_d <= done;
      if (done && !done_d) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(err == e[1], "R2/R4/R5/R6/R7 err verdict", err, e[1]);
          chk(commit == e[0], "R7/R10 commit at done", commit, e[0]);
        end
      end else if (commit) begin
        chk(1'b0, "R10 commit without done rise", 1, 0);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run(input bit lz, input logic [9:0] nl, input logic [3:0] cnt,
                     input bit info, input logic [9:0] re, input bit busy_start);
    logic e_err, e_cmt, fix;
    int sc;
    sc = $signed(cnt);
    fix = 1'b0; e_cmt = 1'b0;
    if (lz) e_err = (nl != 0);
    else if (sc < 0 || sc > 5) e_err = 1'b1;
    else if (sc == 0) e_err = (nl != 0);
    else if (!info) e_err = 1'b0;
    else begin fix = 1'b1; e_err = (re != 0); e_cmt = (re == 0); end
    exp_q.push_back({e_err, e_cmt});

    start = 1'b1; tick(); start = 1'b0;
    @(negedge clk);
    chk(done == 0 && err == 0, "R8 start clears verdict", done, 0);
    tick();
    syn_vld = 1'b1; lin_syn_zero = lz; nl_syn = nl; tick(); syn_vld = 1'b0;
    @(negedge clk);
    if (lz) begin
      chk(done == 1, "R2 early finish cycle", done, 1);
      chk(search_req == 0, "R2 no search", search_req, 0);
      return;
    end
    chk(search_req == 1 && done == 0, "R3 search request", search_req, 1);
    if (busy_start) begin
      tick(); start = 1'b1; tick(); start = 1'b0;
    end else begin
      tick();
    end
    loc_vld = 1'b1; err_cnt = cnt; info_hit = info; tick(); loc_vld = 1'b0;
    @(negedge clk);
    if (!fix) begin
      chk(done == 1, "R4/R5/R6 finish cycle", done, 1);
      chk(recheck_req == 0, "R6 no recheck", recheck_req, 0);
      return;
    end
    chk(recheck_req == 1 && done == 0, "R7 recheck request", recheck_req, 1);
    tick();
    re_vld = 1'b1; re_syn = re; tick(); re_vld = 1'b0;
    @(negedge clk);
    chk(done == 0, "R7 verify cycle", done, 0);
    @(negedge clk);
    chk(done == 1, "R7 finish after verify", done, 1);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 0; syn_vld = 0; lin_syn_zero = 0; nl_syn = 0;
    loc_vld = 0; err_cnt = 0; info_hit = 0; re_vld = 0; re_syn = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && err == 0 && commit == 0 && search_req == 0 && recheck_req == 0,
        "R1 reset state", done, 0);

    run(1, 10'h000, 4'd0, 0, 10'h000, 0);  // R2 clean
    run(1, 10'h155, 4'd0, 0, 10'h000, 0);  // R2 nonlinear only
    run(0, 10'h001, 4'hF, 1, 10'h000, 0);  // R4 failure -1
    run(0, 10'h001, 4'hE, 1, 10'h000, 0);  // R4 negative
    run(0, 10'h001, 4'd6, 1, 10'h000, 0);  // R4 above limit
    run(0, 10'h001, 4'd7, 0, 10'h000, 0);  // R4 max positive
    run(0, 10'h000, 4'd0, 0, 10'h000, 0);  // R5 zero count clean
    run(0, 10'h020, 4'd0, 1, 10'h000, 0);  // R5 zero count dirty
    run(0, 10'h0F0, 4'd3, 0, 10'h000, 0);  // R6 check-only errors
    run(0, 10'h0F0, 4'd5, 1, 10'h000, 0);  // R7 commit at limit
    run(0, 10'h0F0, 4'd1, 1, 10'h200, 0);  // R7 recheck nonzero
    run(0, 10'h033, 4'd2, 1, 10'h000, 1);  // R9 start while busy

    // R8 hold until start
    repeat (4) @(negedge clk);
    chk(done == 1 && err == 0, "R8 verdict held", done, 1);

    // R1 reset mid-decode
    start = 1'b1; tick(); start = 1'b0;
    tick(); syn_vld = 1'b1; lin_syn_zero = 0; nl_syn = 10'h1; tick(); syn_vld = 1'b0;
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && err == 0 && search_req == 0, "R1 reset mid-decode", done, 0);
    run(0, 10'h0F0, 4'd4, 1, 10'h000, 0);  // R7 after reset

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule